// File: doc/BRIEF.md
# BCD Digit Entry Accumulator

This block turns a stream of decimal key presses into a binary number, the way a calculator display or a keypad combination lock builds its value. Every legal digit that arrives while the block is idle makes the running 16-bit total ten times larger and then adds the new digit to it. Because the old total is scaled before the addition, the first digit after a clear lands in the total unchanged.

The multiply by ten uses no multiplier. It is built as the sum of the total shifted left by one place and the total shifted left by three places. The work is spread over a fixed four-state walk: take the digit, form the doubled term, form the eightfold term and add the two, then add the digit and go back to idle. A busy flag covers the working cycles. A sticky overflow flag records any result that did not fit in 16 bits. An active-low seven-segment code shows which state the sequencer is in, which helps with bring-up on a board.

Top module: `bcd_entry_acc`

## Requirements
- R1: While `rst_n` is low, and for the one cycle after it is released, the block sits in the clear state: `busy_o`=1, `seg_n_o` shows 4, `total_o`=0 and `ovf_o`=0. After that it idles with `busy_o`=0.
- R2: An accepted digit d replaces the total T with (10*T + d) mod 65536.
- R3: The first digit accepted after a clear becomes the total without being scaled.
- R4: `total_o` is registered. It changes only at the fourth rising edge counted from, and including, the edge that accepts the digit.
- R5: `busy_o` is high for exactly the three cycles between acceptance and the write of the new total. Digits offered while `busy_o` is high are dropped.
- R6: The block leaves idle only on an edge at which `digit_vld_i` is high.
- R7: Digit codes 10 to 15 are ignored: the block stays idle and the total does not change.
- R8: A result of 65536 or more wraps and sets `ovf_o`. `ovf_o` stays set through later digits until the next reset.
- R9: `seg_n_o` = {a,b,c,d,e,f,g}, active low, shows the state number: idle 0 = 0000001, doubling 1 = 1001111, summing 2 = 0010010, adding 3 = 0000110, clear 4 = 1001100.
- R10: Reset is synchronous and active low. Asserting it in the middle of a sequence drops the digit being processed and leaves the total at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| digit_i | input | 4 | BCD digit code |
| digit_vld_i | input | 1 | Digit strobe, sampled while idle |
| total_o | output | 16 | Accumulated binary total |
| busy_o | output | 1 | High while a digit is being processed or during clear |
| ovf_o | output | 1 | Sticky overflow flag |
| seg_n_o | output | 7 | Active-low segment pattern of the current state |

## Verification
The bench first enters a number that ends at exactly 65535, then one that reaches 65536. A design with a mis-sized adder would wrap too early or miss the flag, and a non-sticky flag would drop on the next digit. It holds a second digit on the strobe during the busy window: a design that samples while busy would pick it up and produce a different total. It also offers codes above nine and pulls reset halfway through a sequence, where a faulty design would fold the digit in or keep a stale total. Because the reference runs cycle by cycle, a design that scaled the first digit or wrote the total one cycle early or late is caught on the very cycle it goes wrong.

// File: rtl/bcd_entry_pkg.sv
// Shared types for the BCD digit entry accumulator.
// Assumes a 3-bit state code whose numeric value is the number shown on the display.
package bcd_entry_pkg;

    typedef enum logic [2:0] {
        ST_CAP = 3'd0,   // idle, waiting to take a digit
        ST_DBL = 3'd1,   // form twice the total
        ST_SUM = 3'd2,   // form eight times the total, add to the doubled term
        ST_ADD = 3'd3,   // add the captured digit, write the total
        ST_CLR = 3'd4    // zero every register
    } acc_state_e;

    // Active-low {a,b,c,d,e,f,g} pattern for a state number 0..4.
    function automatic logic [6:0] seg_for_state(input acc_state_e st);
        logic [6:0] lit;
        case (st)
            ST_CAP:  lit = 7'b1111110;
            ST_DBL:  lit = 7'b0110000;
            ST_SUM:  lit = 7'b1101101;
            ST_ADD:  lit = 7'b1111001;
            default: lit = 7'b0110011;
        endcase
        return ~lit;
    endfunction

endpackage

// File: rtl/bcd_entry_ctrl.sv
// Sequencer for the digit accumulator.
// Leaves idle only on a legal strobed digit, then steps through the three
// working states and returns. Synchronous active-low reset forces the clear state.
module bcd_entry_ctrl
    import bcd_entry_pkg::*;
#(
    parameter int DIG_W   = 4,
    parameter int DIG_MAX = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIG_W-1:0] digit_i,
    input  logic             digit_vld_i,
    output acc_state_e       state_o,
    output logic             accept_o
);

    localparam logic [DIG_W-1:0] LIMIT = DIG_W'(DIG_MAX);

    acc_state_e state_q, state_d;

    // Purpose: qualify a digit offered while idle.
    always_comb begin
        accept_o = (state_q == ST_CAP) && digit_vld_i && (digit_i <= LIMIT);
    end

    // Purpose: next-state selection for the fixed processing walk.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_CLR:  state_d = ST_CAP;
            ST_CAP:  if (accept_o) state_d = ST_DBL;
            ST_DBL:  state_d = ST_SUM;
            ST_SUM:  state_d = ST_ADD;
            ST_ADD:  state_d = ST_CAP;
            default: state_d = ST_CLR;
        endcase
    end

    // Purpose: state register with synchronous reset into the clear state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CLR;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

endmodule

// File: rtl/bcd_entry_dp.sv
// Datapath of the digit accumulator: times-ten by shifts and adds.
// All registers are written from one clocked process. Intermediates are wide
// enough to hold the unwrapped result, so the overflow test is exact.
module bcd_entry_dp
    import bcd_entry_pkg::*;
#(
    parameter int DIG_W = 4,
    parameter int TOT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acc_state_e       state_i,
    input  logic             accept_i,
    input  logic [DIG_W-1:0] digit_i,
    output logic [TOT_W-1:0] total_o,
    output logic             ovf_o
);

    localparam int X2_W  = TOT_W + 1;
    localparam int X8_W  = TOT_W + 3;
    localparam int SUM_W = TOT_W + 4;

    logic [DIG_W-1:0] dig_q;
    logic [X2_W-1:0]  x2_q;
    logic [SUM_W-1:0] x10_q;
    logic [TOT_W-1:0] total_q;
    logic             ovf_q;

    logic [X8_W-1:0]  x8_w;
    logic [SUM_W-1:0] next_w;

    // Purpose: form the eightfold term and the final unwrapped sum.
    always_comb begin
        x8_w   = {total_q, 3'b000};
        next_w = x10_q + SUM_W'(dig_q);
    end

    // Purpose: the single process that owns total, flag and intermediates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dig_q   <= '0;
            x2_q    <= '0;
            x10_q   <= '0;
            total_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            case (state_i)
                ST_CLR: begin
                    dig_q   <= '0;
                    x2_q    <= '0;
                    x10_q   <= '0;
                    total_q <= '0;
                    ovf_q   <= 1'b0;
                end
                ST_CAP: if (accept_i) dig_q <= digit_i;
                ST_DBL: x2_q  <= {total_q, 1'b0};
                ST_SUM: x10_q <= SUM_W'(x2_q) + SUM_W'(x8_w);
                ST_ADD: begin
                    total_q <= next_w[TOT_W-1:0];
                    if (|next_w[SUM_W-1:TOT_W]) ovf_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign total_o = total_q;
    assign ovf_o   = ovf_q;

endmodule

// File: rtl/bcd_entry_seg.sv
// Maps the sequencer state onto an active-low seven-segment pattern.
// Purely combinational; assumes the display order {a,b,c,d,e,f,g}.
module bcd_entry_seg
    import bcd_entry_pkg::*;
(
    input  acc_state_e state_i,
    output logic [6:0] seg_n_o
);

    // Purpose: look up the pattern for the state number.
    always_comb begin
        seg_n_o = seg_for_state(state_i);
    end

endmodule

// File: rtl/bcd_entry_acc.sv
// Top of the BCD digit entry accumulator.
// Ties the sequencer, the times-ten datapath and the state display together.
// Assumes digits are presented on a strobe sampled only while idle.
module bcd_entry_acc
    import bcd_entry_pkg::*;
#(
    parameter int DIG_W   = 4,
    parameter int TOT_W   = 16,
    parameter int DIG_MAX = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIG_W-1:0] digit_i,
    input  logic             digit_vld_i,
    output logic [TOT_W-1:0] total_o,
    output logic             busy_o,
    output logic             ovf_o,
    output logic [6:0]       seg_n_o
);

    acc_state_e state_w;
    logic       accept_w;

    bcd_entry_ctrl #(.DIG_W(DIG_W), .DIG_MAX(DIG_MAX)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .digit_i     (digit_i),
        .digit_vld_i (digit_vld_i),
        .state_o     (state_w),
        .accept_o    (accept_w)
    );

    bcd_entry_dp #(.DIG_W(DIG_W), .TOT_W(TOT_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_i  (state_w),
        .accept_i (accept_w),
        .digit_i  (digit_i),
        .total_o  (total_o),
        .ovf_o    (ovf_o)
    );

    bcd_entry_seg u_seg (
        .state_i (state_w),
        .seg_n_o (seg_n_o)
    );

    // Purpose: busy covers every state except idle.
    always_comb begin
        busy_o = (state_w != ST_CAP);
    end

endmodule

// File: rtl/bcd_entry_acc_chk.sv
// Port-level property checker for the digit accumulator, bound to the top.
module bcd_entry_acc_chk #(
    parameter int DIG_W = 4,
    parameter int TOT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIG_W-1:0] digit_i,
    input logic             digit_vld_i,
    input logic [TOT_W-1:0] total_o,
    input logic             busy_o,
    input logic             ovf_o,
    input logic [6:0]       seg_n_o
);

    AST_IDLE_HOLDS_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(total_o)); // R4

    AST_LEGAL_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && digit_vld_i && digit_i <= 4'd9) |=> busy_o); // R5

    AST_NO_STROBE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !digit_vld_i) |=> !busy_o); // R6

    AST_BAD_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && digit_vld_i && digit_i > 4'd9) |=> (!busy_o && $stable(total_o))); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && $past(rst_n)) |=> ovf_o); // R8

    AST_IDLE_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (seg_n_o == 7'b0000001)); // R9

endmodule

bind bcd_entry_acc bcd_entry_acc_chk #(.DIG_W(DIG_W), .TOT_W(TOT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .digit_i     (digit_i),
    .digit_vld_i (digit_vld_i),
    .total_o     (total_o),
    .busy_o      (busy_o),
    .ovf_o       (ovf_o),
    .seg_n_o     (seg_n_o)
);

// File: tb/sim_bcd_entry_acc.sv
module sim_bcd_entry_acc;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  digit = 4'd0;
    logic        vld = 1'b0;
    logic [15:0] total_o;
    logic        busy_o;
    logic        ovf_o;
    logic [6:0]  seg_n_o;

    int n_vec = 0;
    int n_bad = 0;
    bit armed = 1'b0;
    bit done  = 1'b0;

    // behavioural reference: phase -1 clear, 0 idle, 1..3 working
    int ref_ph    = -1;
    int ref_total = 0;
    int ref_pend  = 0;
    int ref_ovf   = 0;

    bcd_entry_acc u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .digit_i     (digit),
        .digit_vld_i (vld),
        .total_o     (total_o),
        .busy_o      (busy_o),
        .ovf_o       (ovf_o),
        .seg_n_o     (seg_n_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            ref_ph = -1; ref_total = 0; ref_ovf = 0;
        end else begin
            case (ref_ph)
                -1: begin ref_ph = 0; ref_total = 0; ref_ovf = 0; end
                0: if (vld && digit <= 9) begin ref_pend = int'(digit); ref_ph = 1; end
                1: ref_ph = 2;
                2: ref_ph = 3;
                default: begin
                    if (ref_total * 10 + ref_pend > 65535) ref_ovf = 1;
                    ref_total = (ref_total * 10 + ref_pend) % 65536;
                    ref_ph = 0;
                end
            endcase
        end
        armed = 1'b1;
    end

    function automatic int seg_exp(input int ph);
        case (ph)
            0: return 7'b0000001;
            1: return 7'b1001111;
            2: return 7'b0010010;
            3: return 7'b0000110;
            default: return 7'b1001100;
        endcase
    endfunction

    task automatic cmp(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (armed && !done) begin
            cmp("R4 total", int'(total_o), ref_total);
            cmp("R5 busy", int'(busy_o), (ref_ph != 0) ? 1 : 0);
            cmp("R8 overflow", int'(ovf_o), ref_ovf);
            cmp("R9 segment", int'(seg_n_o), seg_exp(ref_ph));
        end
    end

    task automatic key(input int d);
        @(negedge clk); digit = 4'(d); vld = 1'b1;
        @(negedge clk); vld = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        cmp("R1 clear seg", int'(seg_n_o), 7'b1001100);
        cmp("R1 clear busy", int'(busy_o), 1);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R1 idle busy", int'(busy_o), 0);
        cmp("R1 idle total", int'(total_o), 0);
    endtask

    task automatic summary();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cmp("R1 reset total", int'(total_o), 0);
        cmp("R1 reset ovf", int'(ovf_o), 0);
        cmp("R1 reset seg", int'(seg_n_o), 7'b1001100);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R1 idle busy", int'(busy_o), 0);

        // R6: no strobe, no start
        digit = 4'd5;
        repeat (4) @(negedge clk);
        cmp("R6 no strobe busy", int'(busy_o), 0);

        // R3 first digit unscaled, R2 scaling
        key(7);
        cmp("R3 first digit", int'(total_o), 7);
        key(3);
        cmp("R2 two digits", int'(total_o), 73);

        // R7 illegal codes
        @(negedge clk); digit = 4'd12; vld = 1'b1;
        @(negedge clk); vld = 1'b0;
        cmp("R7 code 12 busy", int'(busy_o), 0);
        cmp("R7 code 12 total", int'(total_o), 73);
        @(negedge clk); digit = 4'd15; vld = 1'b1;
        @(negedge clk); vld = 1'b0;
        cmp("R7 code 15 total", int'(total_o), 73);

        // R5 digits during busy are dropped, R4 write timing
        @(negedge clk); digit = 4'd4; vld = 1'b1;
        @(negedge clk); digit = 4'd9;
        cmp("R4 total before write", int'(total_o), 73);
        @(negedge clk);
        @(negedge clk);
        cmp("R4 total still old", int'(total_o), 73);
        vld = 1'b0;
        @(negedge clk);
        cmp("R5 busy drop total", int'(total_o), 734);
        cmp("R5 back idle", int'(busy_o), 0);

        // R10 reset mid-sequence
        @(negedge clk); digit = 4'd8; vld = 1'b1;
        @(negedge clk); vld = 1'b0;
        @(negedge clk);
        do_reset();
        cmp("R10 abandoned total", int'(total_o), 0);
        repeat (3) @(negedge clk);
        cmp("R10 stays zero", int'(total_o), 0);

        // R8 boundary 65535 without overflow
        key(6); key(5); key(5); key(3); key(5);
        cmp("R8 max total", int'(total_o), 65535);
        cmp("R8 no ovf at max", int'(ovf_o), 0);
        do_reset();
        key(6); key(5); key(5); key(3); key(6);
        cmp("R8 wrap total", int'(total_o), 0);
        cmp("R8 ovf set", int'(ovf_o), 1);
        key(5);
        cmp("R2 after wrap", int'(total_o), 5);
        cmp("R8 ovf sticky", int'(ovf_o), 1);
        do_reset();
        cmp("R8 ovf cleared", int'(ovf_o), 0);

        // mixed pattern, including illegal codes and back-to-back strobes
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            digit = 4'((i * 7 + 3) % 16);
            vld   = (i % 3) != 2;
        end
        @(negedge clk); vld = 1'b0;
        repeat (5) @(negedge clk);

        summary();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule